// File: doc/BRIEF.md
# E1 Selectable Line Code Encoder

This block turns a serial E1 NRZ bit stream, one bit per clock, into a line-coded symbol stream for a digital line interface. Four codes are available: AMI, HDB3, plain CMI, and CMI fed from HDB3-substituted ternary symbols. Each bit period leaves the block as two half-period slots, so the same output can carry the two-level CMI waveform and the full-width ternary pulses of AMI and HDB3.

The code and the rail arrangement are taken from the inputs only while the synchronous reset is held. A change to them therefore needs a reset, and that reset also clears the polarity, parity and zero-run history. In dual-rail operation one wire pair carries positive and negative marks. For CMI the pair carries the level and its complement. In single-rail operation one wire carries the line signal and the other stays low. All codes share one pipeline, so the latency is the same in every mode.

Top module: `e1_line_encoder`

## Requirements
- R1: The code is selected by `code_sel` (00 AMI, 01 HDB3, 10 CMI, 11 CMI with HDB3 precoding), and the rail choice by `single_rail`. Both are captured only on clock edges where `rst_n` is low. Changing them while out of reset has no effect on the output.
- R2: The bit captured on clock edge N drives the outputs from edge N+4. Bit [1] of each output is the first half of the bit period and bit [0] is the second half.
- R3: In AMI a zero gives no pulse and each one gives a pulse opposite in polarity to the previous pulse. A ternary pulse fills both halves of the bit period.
- R4: In HDB3 every run of four zeros is replaced. It becomes 000V when the number of pulses since the last substitution is odd, and B00V when that number is even. B takes the polarity opposite to the previous pulse. V takes the same polarity as the previous pulse.
- R5: In HDB3 the line never carries more than three consecutive zero symbols.
- R6: In plain CMI a zero gives halves 01. A one gives a full-period level (11 or 00) that alternates on successive ones, and the first one after reset is 11.
- R7: In CMI with HDB3 precoding a positive ternary symbol gives 11, a negative symbol gives 00, and a space gives 01.
- R8: In dual-rail AMI or HDB3, `line_p` carries positive pulses and `line_n` carries negative pulses. The two are never active in the same bit period.
- R9: In dual-rail CMI modes, `line_p` carries the CMI level and `line_n` carries its bitwise complement.
- R10: In single-rail operation `line_n` is held at 0. `line_p` carries the CMI level in CMI modes and the mark presence (11 for any pulse) in AMI and HDB3.
- R11: While reset is held both outputs are 0. After reset the first pulse is positive and the HDB3 pulse count starts even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one NRZ bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also the window for loading configuration |
| code_sel | input | 2 | Line code select, captured during reset |
| single_rail | input | 1 | 1 selects single-rail output, captured during reset |
| nrz_in | input | 1 | Serial NRZ data bit |
| line_p | output | 2 | Positive rail or single-rail signal, [1] first half-bit |
| line_n | output | 2 | Negative rail or complement, [1] first half-bit |

## Verification
The hardest situation to reach is the HDB3 choice between 000V and B00V. That choice depends on the count of pulses since the last substitution, and it rewrites a symbol three bits back in the pipeline. Directed patterns place zero runs after both odd and even pulse counts, place back-to-back runs with no pulse between them, and place a run that straddles the end of the data so that the padding zeros force a late rewrite. A second run-length case comes from a long all-zero stretch checked against a run counter in the checker.

// File: rtl/e1lc_pkg.sv
// Shared types for the E1 line code encoder.
// Assumes: two half-bit slots per bit period, [1] sent first.
package e1lc_pkg;
    localparam int RUN_LEN = 4;   // HDB3 zero-run length that triggers substitution

    typedef enum logic [1:0] {
        LC_AMI      = 2'b00,
        LC_HDB3     = 2'b01,
        LC_CMI      = 2'b10,
        LC_CMI_HDB3 = 2'b11
    } lc_mode_e;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,
        SYM_MARK  = 2'd1,
        SYM_BPUL  = 2'd2,
        SYM_VPUL  = 2'd3
    } sym_e;

    typedef enum logic [1:0] {
        TER_ZERO = 2'd0,
        TER_POS  = 2'd1,
        TER_NEG  = 2'd2
    } ter_e;
endpackage

// File: rtl/e1lc_subst.sv
// Zero-run substitution pipeline.
// Holds RUN_LEN symbols so that a run of RUN_LEN zeros can be rewritten
// once its last zero arrives: the newest becomes V, and the oldest becomes B
// when the pulse count since the last substitution is even.
// Assumes RUN_LEN >= 2. With subst_en low the pipeline is a plain delay.
module e1lc_subst
    import e1lc_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic subst_en,
    input  logic din,
    output sym_e sym_o
);
    localparam int CW = $clog2(RUN_LEN + 1);

    sym_e          pipe_q [RUN_LEN];
    sym_e          pipe_d [RUN_LEN];
    logic [CW-1:0] zrun_q, zrun_d;
    logic          odd_q, odd_d;
    logic          fire;

    // Next pipeline contents, run counter and pulse parity.
    always_comb begin
        fire      = subst_en && !din && (zrun_q == CW'(RUN_LEN - 1));
        pipe_d[0] = fire ? SYM_VPUL : (din ? SYM_MARK : SYM_SPACE);
        for (int i = 1; i < RUN_LEN; i++) pipe_d[i] = pipe_q[i-1];
        if (fire && !odd_q) pipe_d[RUN_LEN-1] = SYM_BPUL;

        zrun_d = zrun_q;
        if (din || fire)                      zrun_d = '0;
        else if (zrun_q != CW'(RUN_LEN - 1))  zrun_d = zrun_q + CW'(1);

        odd_d = odd_q;
        if (fire)     odd_d = 1'b0;
        else if (din) odd_d = ~odd_q;
    end

    // State registers with synchronous reset to an idle, even-parity line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RUN_LEN; i++) pipe_q[i] <= SYM_SPACE;
            zrun_q <= '0;
            odd_q  <= 1'b0;
        end else begin
            for (int i = 0; i < RUN_LEN; i++) pipe_q[i] <= pipe_d[i];
            zrun_q <= zrun_d;
            odd_q  <= odd_d;
        end
    end

    assign sym_o = pipe_q[RUN_LEN-1];
endmodule

// File: rtl/e1lc_polarity.sv
// Polarity assignment.
// Marks and B pulses alternate from the previous pulse; V repeats it.
// Assumes the first pulse after reset is positive.
module e1lc_polarity
    import e1lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sym_e sym_i,
    output ter_e ter_o
);
    logic last_pos_q;

    // Map the symbol to a signed ternary value.
    always_comb begin
        unique case (sym_i)
            SYM_SPACE:          ter_o = TER_ZERO;
            SYM_MARK, SYM_BPUL: ter_o = last_pos_q ? TER_NEG : TER_POS;
            SYM_VPUL:           ter_o = last_pos_q ? TER_POS : TER_NEG;
            default:            ter_o = TER_ZERO;
        endcase
    end

    // Remember the polarity of the latest pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                  last_pos_q <= 1'b0;
        else if (sym_i != SYM_SPACE) last_pos_q <= (ter_o == TER_POS);
    end
endmodule

// File: rtl/e1lc_rail_map.sv
// Output mapper and register.
// Turns a ternary symbol into two half-bit slots on two rails for the
// selected code family and rail arrangement.
// Assumes cmi and single are static outside reset.
module e1lc_rail_map
    import e1lc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ter_e       ter_i,
    input  logic       cmi,
    input  logic       single,
    output logic [1:0] rail_p_o,
    output logic [1:0] rail_n_o
);
    logic [1:0] level;
    logic [1:0] p_d, n_d;

    // Compute the half-bit slots for both rails.
    always_comb begin
        unique case (ter_i)
            TER_POS: level = 2'b11;
            TER_NEG: level = 2'b00;
            default: level = 2'b01;
        endcase
        if (cmi) begin
            p_d = level;
            n_d = single ? 2'b00 : ~level;
        end else if (single) begin
            p_d = (ter_i != TER_ZERO) ? 2'b11 : 2'b00;
            n_d = 2'b00;
        end else begin
            p_d = (ter_i == TER_POS) ? 2'b11 : 2'b00;
            n_d = (ter_i == TER_NEG) ? 2'b11 : 2'b00;
        end
    end

    // Register the outputs; both rails are low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rail_p_o <= 2'b00;
            rail_n_o <= 2'b00;
        end else begin
            rail_p_o <= p_d;
            rail_n_o <= n_d;
        end
    end
endmodule

// File: rtl/e1_line_encoder.sv
// E1 selectable line code encoder, top level.
// Captures the code and the rail choice while reset is low, then runs the
// substitution pipeline, the polarity stage and the output register.
// Assumes one NRZ bit per clock; latency is RUN_LEN clocks in every mode.
module e1_line_encoder
    import e1lc_pkg::*;
#(
    parameter int RUN_LEN = e1lc_pkg::RUN_LEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_sel,
    input  logic       single_rail,
    input  logic       nrz_in,
    output logic [1:0] line_p,
    output logic [1:0] line_n
);
    lc_mode_e mode_q;
    logic     single_q;
    sym_e     sym;
    ter_e     ter;

    // Configuration is loaded only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= lc_mode_e'(code_sel);
            single_q <= single_rail;
        end
    end

    e1lc_subst #(.RUN_LEN(RUN_LEN)) u_subst (
        .clk     (clk),
        .rst_n   (rst_n),
        .subst_en(mode_q[0]),
        .din     (nrz_in),
        .sym_o   (sym)
    );

    e1lc_polarity u_pol (
        .clk  (clk),
        .rst_n(rst_n),
        .sym_i(sym),
        .ter_o(ter)
    );

    e1lc_rail_map u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .ter_i   (ter),
        .cmi     (mode_q[1]),
        .single  (single_q),
        .rail_p_o(line_p),
        .rail_n_o(line_n)
    );
endmodule

// File: rtl/e1lc_checker.sv
// Property checker for the E1 line encoder, bound to the top.
// Assumes mode_q and single_q are the configuration captured during reset.
module e1lc_checker
    import e1lc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input lc_mode_e   mode_q,
    input logic       single_q,
    input logic       nrz_in,
    input logic [1:0] line_p,
    input logic [1:0] line_n
);
    logic [2:0] warm;
    logic [2:0] zcnt;

    // Count clock edges since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)           warm <= '0;
        else if (warm != 3'd7) warm <= warm + 3'd1;
    end

    // Count consecutive zero symbols on the line once data is flowing.
    always_ff @(posedge clk) begin
        if (!rst_n)            zcnt <= '0;
        else if (warm >= 3'd6) begin
            if (line_p == 2'b00 && line_n == 2'b00) begin
                if (zcnt != 3'd7) zcnt <= zcnt + 3'd1;
            end else begin
                zcnt <= '0;
            end
        end
    end

    a_r8_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[1] && !single_q) |-> !((|line_p) && (|line_n)));

    a_r10_single_n_low: assert property (@(posedge clk) disable iff (!rst_n)
        single_q |-> (line_n == 2'b00));

    a_r6_no_mid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1] |-> (line_p != 2'b10));

    a_r9_cmi_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && !single_q && warm != 3'd0) |-> (line_n == ~line_p));

    a_r3_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[1] |-> (line_p[1] == line_p[0] && line_n[1] == line_n[0]));

    a_r2_zero_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LC_AMI && warm == 3'd7 && $past(nrz_in, 5) == 1'b0)
            |-> (line_p == 2'b00 && line_n == 2'b00));

    a_r5_hdb3_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LC_HDB3) |-> (zcnt <= 3'd3));
endmodule

bind e1_line_encoder e1lc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .single_q(single_q),
    .nrz_in  (nrz_in),
    .line_p  (line_p),
    .line_n  (line_n)
);

// File: tb/e1_line_encoder_tb.sv
// Directed bench for the E1 line encoder: one task per scenario.
module e1_line_encoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] code_sel = 2'b00;
    logic       single_rail = 1'b0;
    logic       nrz_in = 1'b0;
    logic [1:0] line_p, line_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [1:0] exp_p [64];
    logic [1:0] exp_n [64];

    always #4 clk = ~clk;   // 125 MHz

    e1_line_encoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_sel   (code_sel),
        .single_rail(single_rail),
        .nrz_in     (nrz_in),
        .line_p     (line_p),
        .line_n     (line_n)
    );

    task automatic check(input string tag, input int idx,
                         input logic [1:0] ep, input logic [1:0] en);
        n_cmp++;
        if (line_p !== ep || line_n !== en) begin
            n_bad++;
            $display("FAIL %s bit %0d: p=%b n=%b expected p=%b n=%b",
                     tag, idx, line_p, line_n, ep, en);
        end
    endtask

    // Reference built from the requirements, padded with zeros to 64 bits.
    task automatic build_expected(input logic [1:0] mode, input logic sr,
                                  input logic [63:0] pat, input int len);
        int sym [64];
        int ter;
        int zeros = 0;
        bit odd = 0;
        bit lastpos = 0;
        logic [1:0] lvl;
        for (int i = 0; i < 64; i++) sym[i] = (i < len && pat[i]) ? 1 : 0;
        if (mode[0]) begin
            for (int i = 0; i < 64; i++) begin
                if (sym[i] == 1) begin
                    zeros = 0;
                    odd = ~odd;
                end else begin
                    zeros++;
                    if (zeros == 4) begin
                        sym[i] = 3;
                        if (!odd) sym[i-3] = 2;
                        zeros = 0;
                        odd = 0;
                    end
                end
            end
        end
        for (int i = 0; i < 64; i++) begin
            case (sym[i])
                1, 2:    ter = lastpos ? -1 : 1;
                3:       ter = lastpos ? 1 : -1;
                default: ter = 0;
            endcase
            if (ter != 0) lastpos = (ter > 0);
            lvl = (ter > 0) ? 2'b11 : (ter < 0) ? 2'b00 : 2'b01;
            if (mode[1]) begin
                exp_p[i] = lvl;
                exp_n[i] = sr ? 2'b00 : ~lvl;
            end else if (sr) begin
                exp_p[i] = (ter != 0) ? 2'b11 : 2'b00;
                exp_n[i] = 2'b00;
            end else begin
                exp_p[i] = (ter > 0) ? 2'b11 : 2'b00;
                exp_n[i] = (ter < 0) ? 2'b11 : 2'b00;
            end
        end
    endtask

    // Reset with one configuration, run with possibly another, compare.
    task automatic run(input logic [1:0] m_rst, input logic [1:0] m_run,
                       input logic sr, input logic [63:0] pat, input int len,
                       input string tag);
        build_expected(m_rst, sr, pat, len);
        @(negedge clk);
        rst_n = 1'b0; code_sel = m_rst; single_rail = sr; nrz_in = 1'b0;
        repeat (2) @(negedge clk);
        check({"R11 reset ", tag}, -1, 2'b00, 2'b00);
        rst_n = 1'b1; code_sel = m_run;
        for (int j = 0; j < len + 5; j++) begin
            if (j > 0) @(negedge clk);
            if (j >= 5) check(tag, j - 5, exp_p[j-5], exp_n[j-5]);
            nrz_in = (j < len) ? pat[j] : 1'b0;
        end
    endtask

    task automatic t_ami();
        run(2'b00, 2'b00, 1'b0, 64'h0000_0000_00B3_96CD, 32, "R3/R8/R2 AMI");
    endtask

    task automatic t_hdb3();
        // pulse then run (odd -> 000V), two pulses then run (even -> B00V),
        // back-to-back runs, long zero stretch, run crossing the end
        run(2'b01, 2'b01, 1'b0, 64'h0000_0000_4010_0061, 40, "R4/R5/R8 HDB3");
        run(2'b01, 2'b01, 1'b0, 64'h0000_0000_0000_0000, 24, "R5 HDB3 zeros");
    endtask

    task automatic t_cmi();
        run(2'b10, 2'b10, 1'b0, 64'h0000_0000_7A53_C90E, 32, "R6/R9 CMI");
    endtask

    task automatic t_cmi_hdb3();
        run(2'b11, 2'b11, 1'b0, 64'h0000_0000_0810_0C41, 32, "R7/R9 CMI+HDB3");
    endtask

    task automatic t_single();
        run(2'b01, 2'b01, 1'b1, 64'h0000_0000_0201_8035, 28, "R10 single HDB3");
        run(2'b10, 2'b10, 1'b1, 64'h0000_0000_00D2_6B31, 24, "R10 single CMI");
    endtask

    task automatic t_mode_hold();
        // code_sel switches to CMI after release; output must stay AMI
        run(2'b00, 2'b10, 1'b0, 64'h0000_0000_0005_A2D3, 20, "R1 mode held");
    endtask

    task automatic t_restart();
        // previous run ended on a positive pulse; first pulse must be positive again
        run(2'b00, 2'b00, 1'b0, 64'h0000_0000_0000_0001, 1, "R11 prep");
        run(2'b00, 2'b00, 1'b0, 64'h0000_0000_0000_0009, 6, "R11 first mark");
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000) begin
                n_bad++;
                $display("FAIL watchdog (R1 to R11 not completed): cycles=%0d expected<=50000", cyc);
                finish_up();
            end
        end
    end

    initial begin
        t_ami();
        t_hdb3();
        t_cmi();
        t_cmi_hdb3();
        t_single();
        t_mode_hold();
        t_restart();
        done = 1;
        finish_up();
    end
endmodule